// File: doc/BRIEF.md
# Dual-Input Programmable Divider with Phase Comparator

This block sits in the digital core of a tuner frequency synthesizer. It takes two local-oscillator signals, a high-band one and a low-band one. A band-select bit picks one of them, and the block counts rising edges of that signal down from a programmed ratio. Each time the count runs out it emits a one-cycle feedback tick. The feedback tick is compared with a reference tick in a three-state phase-frequency comparator. The comparator result drives two charge-pump outputs, each described by a level and an output enable. A cleared enable means high impedance.

A single 14-bit ratio field serves both bands. The high band divides by the whole field. The low band divides by the upper ten bits only, so its ratio steps are coarser. A ratio that is too small to count (0 or 1) is raised to 2. A new ratio is picked up at the next reload, so an interval already in progress keeps its old length. The oscillator inputs are brought into the system clock domain through synchronizers. Each must therefore run at no more than a quarter of the clock rate.

Top module: `pll_divcmp`

## Requirements
- R1: With `band_sel` = 1, the feedback tick repeats once every N rising edges of `osc_hi`, where N is the 14-bit `divisor` (bit 0 least significant).
- R2: With `band_sel` = 0, N is `divisor[13:4]`, and `divisor[3:0]` has no effect on the tick period.
- R3: Only the selected oscillator is counted; edges on the other oscillator do not change the tick period.
- R4: An effective ratio of 0 or 1 on the selected path divides by 2.
- R5: A `divisor` change during an interval does not alter that interval; the new ratio applies from the next reload on.
- R6: A reference tick that arrives while the comparator is idle, and without a feedback tick in the same cycle, drives pump A high and pump B low (both enabled) from the next cycle. This state holds until a feedback tick arrives.
- R7: A feedback tick that arrives while the comparator is idle, and without a reference tick in the same cycle, drives pump A low and pump B high (both enabled) from the next cycle.
- R8: Once both ticks have arrived, both pumps go high impedance (enable 0) in the next cycle. Ticks that coincide while idle leave both pumps high impedance.
- R9: During reset and after it, until the first tick, both pump enables are 0 and `div_tick` is 0.
- R10: `div_tick` is high for exactly one clock cycle per divided period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| osc_hi | input | 1 | High-band local-oscillator signal (asynchronous) |
| osc_lo | input | 1 | Low-band local-oscillator signal (asynchronous) |
| band_sel | input | 1 | 1 counts `osc_hi` with the full field, 0 counts `osc_lo` with bits 13:4 |
| divisor | input | 14 | Shared division ratio field |
| ref_tick | input | 1 | One-cycle reference pulse |
| div_tick | output | 1 | One-cycle divided feedback pulse |
| pump_a_lvl | output | 1 | Pump A level: 1 when pumping up |
| pump_a_oe | output | 1 | Pump A enable; 0 means high impedance |
| pump_b_lvl | output | 1 | Pump B level: 1 when pumping down (inverted sense) |
| pump_b_oe | output | 1 | Pump B enable; 0 means high impedance |

## Verification
The bench measures the spacing of feedback ticks in clock cycles and compares it with N times the oscillator period. It sweeps ratios on both bands, including ones whose value lives in bit 4. A path that muxed the wrong field or band would show a period off by a factor of 16 or 1.5. It also sets the low four bits, which a low-band design that failed to drop them would count. Ratios 0 and 1 are tried on both paths; a missing clamp would either stall the counter or fire every edge. The bench changes the ratio in mid-interval; an immediate load would shorten that interval. In the comparator checks, up and down are each provoked from idle, and coincident ticks are applied. A comparator with swapped polarity, or one that failed to clear on the second edge, would leave a pump enabled or driven the wrong way.

// File: rtl/pll_divcmp_pkg.sv
package pll_divcmp_pkg;

  // Phase comparator state
  typedef enum logic [1:0] {
    PD_IDLE = 2'd0,
    PD_UP   = 2'd1,
    PD_DN   = 2'd2
  } pd_state_e;

endpackage

// File: rtl/osc_edge_det.sv
// Synchronizes an asynchronous oscillator signal and flags its rising edges.
module osc_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_in,
  output logic rise_o
);

  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], osc_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/pll_ratio_sel.sv
// Picks the ratio field for the active band and clamps it to the minimum.
module pll_ratio_sel #(
  parameter int DIV_W     = 14,
  parameter int LO_SHIFT  = 4,
  parameter int MIN_RATIO = 2
) (
  input  logic             band_sel,
  input  logic [DIV_W-1:0] divisor,
  output logic [DIV_W-1:0] ratio
);

  localparam logic [DIV_W-1:0] MinVal = DIV_W'(MIN_RATIO);

  logic [DIV_W-1:0] raw;

  always_comb begin
    raw   = band_sel ? divisor : (divisor >> LO_SHIFT);
    ratio = (raw < MinVal) ? MinVal : raw;
  end

endmodule

// File: rtl/pll_prog_ctr.sv
// Down counter: reloads on terminal count and emits one tick per ratio edges.
module pll_prog_ctr #(
  parameter int DIV_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [DIV_W-1:0] ratio,
  output logic             tick_o
);

  localparam logic [DIV_W-1:0] One = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             tick_q, tick_d;

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (cnt_en) begin
      if (cnt_q <= One) begin
        cnt_d  = ratio;
        tick_d = 1'b1;
      end else begin
        cnt_d  = cnt_q - One;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

endmodule

// File: rtl/pll_pfd.sv
// Three-state phase-frequency comparator.
module pll_pfd
  import pll_divcmp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ref_i,
  input  logic fb_i,
  output logic up_o,
  output logic dn_o
);

  pd_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PD_IDLE: begin
        if (ref_i && !fb_i)      st_d = PD_UP;
        else if (fb_i && !ref_i) st_d = PD_DN;
      end
      PD_UP:   if (fb_i)  st_d = PD_IDLE;
      PD_DN:   if (ref_i) st_d = PD_IDLE;
      default: st_d = PD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PD_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  assign up_o = (st_q == PD_UP);
  assign dn_o = (st_q == PD_DN);

endmodule

// File: rtl/pll_divcmp.sv
// Dual-input programmable divider with phase comparator and pump enables.
module pll_divcmp #(
  parameter int DIV_W       = 14,
  parameter int LO_SHIFT    = 4,
  parameter int MIN_RATIO   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_hi,
  input  logic             osc_lo,
  input  logic             band_sel,
  input  logic [DIV_W-1:0] divisor,
  input  logic             ref_tick,
  output logic             div_tick,
  output logic             pump_a_lvl,
  output logic             pump_a_oe,
  output logic             pump_b_lvl,
  output logic             pump_b_oe
);

  localparam int NumOsc = 2;

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign srst_n = rst_sync_q[1];

  // Oscillator edge detection, index 1 = high band, 0 = low band
  logic [NumOsc-1:0] osc_vec;
  logic [NumOsc-1:0] rise_vec;

  assign osc_vec = {osc_hi, osc_lo};

  for (genvar g = 0; g < NumOsc; g++) begin : g_osc
    osc_edge_det #(
      .STAGES (SYNC_STAGES)
    ) u_edge (
      .clk    (clk),
      .rst_n  (srst_n),
      .osc_in (osc_vec[g]),
      .rise_o (rise_vec[g])
    );
  end

  logic             cnt_en;
  logic [DIV_W-1:0] ratio;

  assign cnt_en = band_sel ? rise_vec[1] : rise_vec[0];

  pll_ratio_sel #(
    .DIV_W     (DIV_W),
    .LO_SHIFT  (LO_SHIFT),
    .MIN_RATIO (MIN_RATIO)
  ) u_ratio (
    .band_sel (band_sel),
    .divisor  (divisor),
    .ratio    (ratio)
  );

  pll_prog_ctr #(
    .DIV_W (DIV_W)
  ) u_ctr (
    .clk    (clk),
    .rst_n  (srst_n),
    .cnt_en (cnt_en),
    .ratio  (ratio),
    .tick_o (div_tick)
  );

  logic pd_up, pd_dn;

  pll_pfd u_pfd (
    .clk   (clk),
    .rst_n (srst_n),
    .ref_i (ref_tick),
    .fb_i  (div_tick),
    .up_o  (pd_up),
    .dn_o  (pd_dn)
  );

  // Pump A pumps up with a high level, pump B has the inverted sense
  assign pump_a_oe  = pd_up | pd_dn;
  assign pump_a_lvl = pd_up;
  assign pump_b_oe  = pd_up | pd_dn;
  assign pump_b_lvl = pd_dn;

endmodule

// File: rtl/pll_divcmp_chk.sv
module pll_divcmp_chk (
  input logic clk,
  input logic rst_n,
  input logic ref_tick,
  input logic div_tick,
  input logic pump_a_lvl,
  input logic pump_a_oe,
  input logic pump_b_lvl,
  input logic pump_b_oe
);

  AST_UP_ON_REF_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_tick && !div_tick && !pump_a_oe) |=> (pump_a_oe && pump_a_lvl && pump_b_oe && !pump_b_lvl)); // R6

  AST_DN_ON_FB_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (div_tick && !ref_tick && !pump_a_oe) |=> (pump_a_oe && !pump_a_lvl && pump_b_oe && pump_b_lvl)); // R7

  AST_CLEAR_ON_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_a_oe && pump_a_lvl && div_tick) |=> (!pump_a_oe && !pump_b_oe)); // R8

  AST_COINCIDENT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_tick && div_tick && !pump_a_oe) |=> !pump_a_oe); // R8

  AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    div_tick |=> !div_tick); // R10

  AST_DOWN_NEEDS_FB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pump_b_lvl) |-> $past(div_tick)); // R7

endmodule

bind pll_divcmp pll_divcmp_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ref_tick   (ref_tick),
  .div_tick   (div_tick),
  .pump_a_lvl (pump_a_lvl),
  .pump_a_oe  (pump_a_oe),
  .pump_b_lvl (pump_b_lvl),
  .pump_b_oe  (pump_b_oe)
);

// File: tb/pll_divcmp_test.sv
`timescale 1ns/1ps
module pll_divcmp_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        osc_hi, osc_lo;
  logic        band_sel;
  logic [13:0] divisor;
  logic        ref_tick;
  logic        div_tick;
  logic        pump_a_lvl, pump_a_oe, pump_b_lvl, pump_b_oe;

  int checks = 0;
  int errors = 0;
  bit run    = 1'b0;
  localparam int HiHalf = 2;
  localparam int LoHalf = 3;

  always #2.5 clk = ~clk;

  pll_divcmp uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_hi     (osc_hi),
    .osc_lo     (osc_lo),
    .band_sel   (band_sel),
    .divisor    (divisor),
    .ref_tick   (ref_tick),
    .div_tick   (div_tick),
    .pump_a_lvl (pump_a_lvl),
    .pump_a_oe  (pump_a_oe),
    .pump_b_lvl (pump_b_lvl),
    .pump_b_oe  (pump_b_oe)
  );

  // Oscillator generators: toggle every HiHalf / LoHalf clock cycles
  initial begin
    int c = 0;
    osc_hi = 1'b0;
    forever begin
      @(negedge clk);
      if (!run) begin
        osc_hi = 1'b0;
        c = 0;
      end else begin
        c++;
        if (c >= HiHalf) begin
          c = 0;
          osc_hi = ~osc_hi;
        end
      end
    end
  end

  initial begin
    int c = 0;
    osc_lo = 1'b0;
    forever begin
      @(negedge clk);
      if (!run) begin
        osc_lo = 1'b0;
        c = 0;
      end else begin
        c++;
        if (c >= LoHalf) begin
          c = 0;
          osc_lo = ~osc_lo;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!div_tick);
  endtask

  task automatic count_to_tick(inout int c);
    do begin
      @(negedge clk);
      c++;
    end while (!div_tick);
  endtask

  // Settle on the programmed ratio, then measure one full interval
  task automatic period_check(input bit sel, input int dv, input string req);
    int raw, n, half, p;
    band_sel = sel;
    divisor  = 14'(dv);
    raw  = sel ? dv : (dv >> 4);
    n    = (raw < 2) ? 2 : raw;
    half = sel ? HiHalf : LoHalf;
    wait_tick();
    wait_tick();
    p = 0;
    count_to_tick(p);
    chk(p == n * 2 * half, req, p, n * 2 * half);
  endtask

  initial begin
    int watch = 0;
    while (watch < 200000) begin
      @(posedge clk);
      watch++;
    end
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", watch, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int hv[7] = '{2, 3, 7, 16, 1007, 1, 0};
    int lv[6] = '{32, 63, 144, 2320, 31, 15};
    int p;
    rst_n    = 1'b0;
    band_sel = 1'b1;
    divisor  = 14'd2;
    ref_tick = 1'b0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(!pump_a_oe && !pump_b_oe, "R9 pumps hi-Z in reset", pump_a_oe, 0);
    chk(!div_tick, "R9 no tick in reset", div_tick, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!pump_a_oe && !pump_b_oe && !div_tick, "R9 idle after reset", pump_a_oe, 0);
    run = 1'b1;

    // R1 / R3 / R4: high band sweep, including clamp of 1 and 0
    foreach (hv[i]) period_check(1'b1, hv[i], (hv[i] < 2) ? "R4 hi clamp" : "R1 R3 hi period");
    // R2 / R3 / R4: low band sweep, low bits set in 63 / 31 / 15
    foreach (lv[i]) period_check(1'b0, lv[i], ((lv[i] >> 4) < 2) ? "R4 lo clamp" : "R2 R3 lo period");

    // R5: change ratio mid-interval
    period_check(1'b1, 10, "R1 hi period");
    p = 0;
    repeat (3) begin
      @(negedge clk);
      p++;
    end
    divisor = 14'd3;
    count_to_tick(p);
    chk(p == 10 * 2 * HiHalf, "R5 old ratio kept", p, 10 * 2 * HiHalf);
    p = 0;
    count_to_tick(p);
    chk(p == 3 * 2 * HiHalf, "R5 new ratio at reload", p, 3 * 2 * HiHalf);

    // R10: tick width
    wait_tick();
    @(negedge clk);
    chk(!div_tick, "R10 tick one cycle", div_tick, 0);

    // Comparator: restart from a clean state with oscillators stopped
    run = 1'b0;
    rst_n = 1'b0;
    divisor = 14'd2;
    band_sel = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(!pump_a_oe, "R9 idle before compare", pump_a_oe, 0);

    // R6: reference leads
    ref_tick = 1'b1;
    @(negedge clk);
    ref_tick = 1'b0;
    chk(pump_a_oe && pump_a_lvl && pump_b_oe && !pump_b_lvl, "R6 up drive", {pump_a_oe, pump_a_lvl, pump_b_oe, pump_b_lvl}, 4'b1110);
    repeat (5) @(negedge clk);
    chk(pump_a_oe && pump_a_lvl, "R6 up held", {pump_a_oe, pump_a_lvl}, 2'b11);
    run = 1'b1;
    wait_tick();
    @(negedge clk);
    chk(!pump_a_oe && !pump_b_oe, "R8 cleared after up", {pump_a_oe, pump_b_oe}, 0);

    // R7: divided edge leads, then reference clears
    wait_tick();
    @(negedge clk);
    chk(pump_a_oe && !pump_a_lvl && pump_b_oe && pump_b_lvl, "R7 down drive", {pump_a_oe, pump_a_lvl, pump_b_oe, pump_b_lvl}, 4'b1011);
    ref_tick = 1'b1;
    @(negedge clk);
    ref_tick = 1'b0;
    chk(!pump_a_oe && !pump_b_oe, "R8 cleared after down", {pump_a_oe, pump_b_oe}, 0);

    // R8: coincident ticks from idle
    wait_tick();
    ref_tick = 1'b1;
    @(negedge clk);
    ref_tick = 1'b0;
    chk(!pump_a_oe && !pump_b_oe, "R8 coincident stays hi-Z", {pump_a_oe, pump_b_oe}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule